// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block guards a processor against runaway software. Software controls it through a single write port that carries an enable flag and a small key. Once armed, the watchdog counts clock cycles. If software does not service it within a first window, it raises a non-maskable interrupt request. That request gives the handler a chance to record state. If the watchdog is still unserviced after a second, shorter window, it drives a chip reset request of fixed length and then falls back to the stopped state.

Servicing is guarded by a key. To restart or stop the count, software must write the bitwise complement of the key it stored last. Any other key value is taken as a silent key change: the key is replaced and the count continues untouched. Code that has lost track of the key therefore cannot keep the watchdog alive by accident.

All three intervals are parameters counted in clock cycles. A system can set them to its real timeout values, and a simulation can shorten them.

Top module: `keyguard_watchdog`

## Requirements
- R1: After reset the watchdog is stopped with both `nmi_req_o` and `rst_req_o` low. A reset asserted while the watchdog is armed returns it to stopped with both outputs low.
- R2: Write format: `wr_data[KEY_W]` is the enable flag and `wr_data[KEY_W-1:0]` is the key. While stopped, a write with enable low has no effect, and no interrupt request follows.
- R3: While stopped, a write with enable high arms the watchdog and stores the written key. `nmi_req_o` rises exactly FIRST_CYCLES clock edges after the edge that took the write.
- R4: While armed or warning, a write whose key is the bitwise complement of the stored key and whose enable is high restarts the first window, stores the written key and clears `nmi_req_o` on the following edge.
- R5: While armed or warning, a write with the complemented key and enable low stops the watchdog. `nmi_req_o` is low after that edge, and no request follows.
- R6: While armed or warning, a write with any key other than the complement replaces the stored key, whatever the enable value. It neither restarts nor stops the count, and it leaves `nmi_req_o` unchanged. Later service must use the complement of the new key.
- R7: Once raised, `nmi_req_o` stays high until a valid restart, a valid stop, or entry into the reset stage.
- R8: If `nmi_req_o` has been high for SECOND_CYCLES edges without service, `rst_req_o` rises and `nmi_req_o` falls on the same edge.
- R9: `rst_req_o` stays high for exactly PULSE_CYCLES cycles. Writes are ignored during the pulse. Afterwards the watchdog is stopped.
- R10: A valid restart taken on the very edge at which a window expires wins over the expiry.
- R11: `nmi_req_o` and `rst_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_data | input | KEY_W+1 | Enable flag in the top bit, key in the lower bits |
| nmi_req_o | output | 1 | Non-maskable interrupt request, first stage |
| rst_req_o | output | 1 | Chip reset request pulse, second stage |

## Verification
The hardest situation to reach is a write that lands on the same edge as a window expiry. The bench arms the watchdog, counts out exactly FIRST_CYCLES-1 edges, and then issues the restart so that it is taken on the expiry edge. A second hard case is a correctly keyed write that arrives during the reset pulse, where the valid key must still be ignored; the stimulus lets a full expiry run and issues that write mid-pulse. Key changes are exercised by writing the complement of the superseded key after a rekey, which must be treated as another rekey rather than as service.

// File: rtl/kgw_pkg.sv
package kgw_pkg;
  typedef enum logic [1:0] {
    WD_STOPPED = 2'd0,
    WD_ARMED   = 2'd1,
    WD_WARN    = 2'd2,
    WD_RESET   = 2'd3
  } wd_state_e;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_START   = 3'd1,
    ACT_RESTART = 3'd2,
    ACT_STOP    = 3'd3,
    ACT_REKEY   = 3'd4
  } wd_act_e;
endpackage

// File: rtl/kgw_cmd_decode.sv
module kgw_cmd_decode
  import kgw_pkg::*;
#(
  parameter int KEY_W = 3
) (
  input  wd_state_e        state,
  input  logic [KEY_W-1:0] key_q,
  input  logic             wr_en,
  input  logic [KEY_W:0]   wr_data,
  output wd_act_e          act
);
  logic             en_bit;
  logic [KEY_W-1:0] wkey;
  logic             inv_match;

  assign en_bit    = wr_data[KEY_W];
  assign wkey      = wr_data[KEY_W-1:0];
  assign inv_match = (wkey == ~key_q);

  always_comb begin
    act = ACT_NONE;
    if (wr_en) begin
      case (state)
        WD_STOPPED: if (en_bit) act = ACT_START;
        WD_ARMED, WD_WARN: begin
          if (inv_match) act = en_bit ? ACT_RESTART : ACT_STOP;
          else           act = ACT_REKEY;
        end
        default: act = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/kgw_down_counter.sv
module kgw_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/keyguard_watchdog.sv
module keyguard_watchdog
  import kgw_pkg::*;
#(
  parameter int KEY_W         = 3,
  parameter int FIRST_CYCLES  = 12_500_000,
  parameter int SECOND_CYCLES = 412_500,
  parameter int PULSE_CYCLES  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [KEY_W:0] wr_data,
  output logic           nmi_req_o,
  output logic           rst_req_o
);
  localparam int MAX_AB = (FIRST_CYCLES > SECOND_CYCLES) ? FIRST_CYCLES : SECOND_CYCLES;
  localparam int MAX_C  = (MAX_AB > PULSE_CYCLES) ? MAX_AB : PULSE_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LD_FIRST  = CNT_W'(FIRST_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_SECOND = CNT_W'(SECOND_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYCLES - 1);

  wd_state_e        state_q, state_n;
  logic [KEY_W-1:0] key_q, key_n;
  logic             nmi_n, rstr_n;
  wd_act_e          act;
  logic             ld, dec, zero;
  logic [CNT_W-1:0] ld_val;
  logic [KEY_W-1:0] wkey;

  assign wkey = wr_data[KEY_W-1:0];

  kgw_cmd_decode #(.KEY_W(KEY_W)) u_dec (
    .state   (state_q),
    .key_q   (key_q),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .act     (act)
  );

  kgw_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .dec      (dec),
    .zero     (zero)
  );

  always_comb begin
    state_n = state_q;
    key_n   = key_q;
    nmi_n   = nmi_req_o;
    rstr_n  = rst_req_o;
    ld      = 1'b0;
    ld_val  = '0;
    dec     = 1'b0;
    case (state_q)
      WD_STOPPED: begin
        if (act == ACT_START) begin
          state_n = WD_ARMED;
          key_n   = wkey;
          ld      = 1'b1;
          ld_val  = LD_FIRST;
        end
      end
      WD_ARMED, WD_WARN: begin
        if (act == ACT_RESTART) begin
          state_n = WD_ARMED;
          key_n   = wkey;
          nmi_n   = 1'b0;
          ld      = 1'b1;
          ld_val  = LD_FIRST;
        end else if (act == ACT_STOP) begin
          state_n = WD_STOPPED;
          key_n   = wkey;
          nmi_n   = 1'b0;
        end else begin
          if (act == ACT_REKEY) key_n = wkey;
          if (!zero) begin
            dec = 1'b1;
          end else if (state_q == WD_ARMED) begin
            state_n = WD_WARN;
            nmi_n   = 1'b1;
            ld      = 1'b1;
            ld_val  = LD_SECOND;
          end else begin
            state_n = WD_RESET;
            nmi_n   = 1'b0;
            rstr_n  = 1'b1;
            ld      = 1'b1;
            ld_val  = LD_PULSE;
          end
        end
      end
      default: begin
        if (zero) begin
          state_n = WD_STOPPED;
          rstr_n  = 1'b0;
        end else begin
          dec = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WD_STOPPED;
      key_q     <= '0;
      nmi_req_o <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      state_q   <= state_n;
      key_q     <= key_n;
      nmi_req_o <= nmi_n;
      rst_req_o <= rstr_n;
    end
  end
endmodule

// File: rtl/kgw_checker.sv
module kgw_checker
  import kgw_pkg::*;
#(
  parameter int KEY_W        = 3,
  parameter int PULSE_CYCLES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [KEY_W:0]   wr_data,
  input logic             nmi_req_o,
  input logic             rst_req_o,
  input wd_state_e        state_q,
  input logic [KEY_W-1:0] key_q
);
  localparam int PW = $clog2(PULSE_CYCLES + 2);
  logic [PW-1:0] hi_run;
  logic          live;
  logic          inv_wr;

  assign live   = (state_q == WD_ARMED) || (state_q == WD_WARN);
  assign inv_wr = wr_en && (wr_data[KEY_W-1:0] == ~key_q);

  always_ff @(posedge clk) begin
    if (rst)            hi_run <= '0;
    else if (rst_req_o) hi_run <= hi_run + 1'b1;
    else                hi_run <= '0;
  end

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(nmi_req_o && rst_req_o));

  assert_stopped_ignore_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_STOPPED && wr_en && !wr_data[KEY_W]) |=> (state_q == WD_STOPPED));

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (live && inv_wr && wr_data[KEY_W]) |=> (!nmi_req_o && state_q == WD_ARMED));

  assert_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (live && inv_wr && !wr_data[KEY_W]) |=> (!nmi_req_o && state_q == WD_STOPPED));

  assert_rekey_R6: assert property (@(posedge clk) disable iff (rst)
    (live && wr_en && !inv_wr) |=> (key_q == $past(wr_data[KEY_W-1:0])));

  assert_escalate_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past(nmi_req_o));

  assert_pulse_max_R9: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> (hi_run < PW'(PULSE_CYCLES)));

  assert_pulse_len_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req_o) |-> (hi_run == PW'(PULSE_CYCLES) && state_q == WD_STOPPED));
endmodule

bind keyguard_watchdog kgw_checker #(.KEY_W(KEY_W), .PULSE_CYCLES(PULSE_CYCLES)) u_kgw_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .nmi_req_o (nmi_req_o),
  .rst_req_o (rst_req_o),
  .state_q   (state_q),
  .key_q     (key_q)
);

// File: tb/tb_keyguard_watchdog.sv
`timescale 1ns/1ps
module tb_keyguard_watchdog;
  localparam int KW = 3;
  localparam int F  = 20;
  localparam int S  = 8;
  localparam int P  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [KW:0]   wr_data = '0;
  logic          nmi_req_o, rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyguard_watchdog #(.KEY_W(KW), .FIRST_CYCLES(F), .SECOND_CYCLES(S), .PULSE_CYCLES(P)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .nmi_req_o(nmi_req_o), .rst_req_o(rst_req_o)
  );

  // Behavioural reference: phase 0 stopped, 1 armed, 2 warning, 3 reset pulse
  int m_phase = 0;
  int m_key = 0;
  int m_age = 0;
  bit m_nmi = 0;
  bit m_rst = 0;

  always @(posedge clk) begin
    int wk;
    bit en, good;
    wk = int'(wr_data[KW-1:0]);
    en = wr_data[KW];
    good = wr_en && ((wk ^ m_key) == 7);
    if (rst) begin
      m_phase = 0; m_key = 0; m_age = 0; m_nmi = 0; m_rst = 0;
    end else if (m_phase == 0) begin
      if (wr_en && en) begin m_phase = 1; m_key = wk; m_age = 0; end
    end else if (m_phase == 3) begin
      if (m_age + 1 == P) begin m_phase = 0; m_rst = 0; end
      else m_age++;
    end else if (good) begin
      m_key = wk; m_nmi = 0; m_age = 0;
      m_phase = en ? 1 : 0;
    end else begin
      if (wr_en) m_key = wk;
      if (m_phase == 1 && m_age + 1 == F) begin
        m_phase = 2; m_nmi = 1; m_age = 0;
      end else if (m_phase == 2 && m_age + 1 == S) begin
        m_phase = 3; m_nmi = 0; m_rst = 1; m_age = 0;
      end else m_age++;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 nmi_req_o vs model", nmi_req_o, m_nmi);
      chk("R9 rst_req_o vs model", rst_req_o, m_rst);
      chk("R11 exclusive", nmi_req_o & rst_req_o, 1'b0);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic wr(input logic en, input logic [KW-1:0] k);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {en, k};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset nmi", nmi_req_o, 1'b0);
    chk("R1 reset rst", rst_req_o, 1'b0);

    wr(1'b0, 3'b101);
    idle(2 * F);
    chk("R2 disabled write ignored", nmi_req_o, 1'b0);

    wr(1'b1, 3'b010);
    idle(F - 1);
    chk("R3 nmi not yet", nmi_req_o, 1'b0);
    idle(1);
    chk("R3 nmi at first timeout", nmi_req_o, 1'b1);
    idle(S - 2);
    chk("R7 nmi held", nmi_req_o, 1'b1);
    wr(1'b1, 3'b101);
    chk("R4 restart clears nmi", nmi_req_o, 1'b0);

    idle(5);
    wr(1'b1, 3'b001);
    idle(F - 8);
    chk("R6 rekey kept count low", nmi_req_o, 1'b0);
    idle(1);
    chk("R6 rekey did not restart", nmi_req_o, 1'b1);
    wr(1'b1, 3'b010);
    chk("R6 stale complement is rekey", nmi_req_o, 1'b1);
    wr(1'b1, 3'b101);
    chk("R4 complement of new key restarts", nmi_req_o, 1'b0);

    wr(1'b0, 3'b010);
    chk("R5 stop clears nmi", nmi_req_o, 1'b0);
    idle(3 * F);
    chk("R5 stays stopped", nmi_req_o, 1'b0);

    wr(1'b1, 3'b000);
    idle(F - 1);
    idle(1);
    chk("R3 nmi after start", nmi_req_o, 1'b1);
    idle(S - 1);
    chk("R8 rst not yet", rst_req_o, 1'b0);
    idle(1);
    chk("R8 rst rises", rst_req_o, 1'b1);
    chk("R8 nmi falls", nmi_req_o, 1'b0);
    wr(1'b1, 3'b111);
    idle(P - 3);
    chk("R9 pulse still high", rst_req_o, 1'b1);
    idle(1);
    chk("R9 pulse ends", rst_req_o, 1'b0);
    idle(2 * F);
    chk("R9 write during pulse ignored", nmi_req_o, 1'b0);

    wr(1'b1, 3'b011);
    idle(F - 2);
    wr(1'b1, 3'b100);
    chk("R10 restart beats expiry", nmi_req_o, 1'b0);
    idle(F - 1);
    chk("R10 new window low", nmi_req_o, 1'b0);
    idle(1);
    chk("R10 new window expires", nmi_req_o, 1'b1);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset nmi", nmi_req_o, 1'b0);
    chk("R1 mid-run reset rst", rst_req_o, 1'b0);
    idle(2 * F);
    chk("R1 stopped after reset", nmi_req_o, 1'b0);

    finish_run();
  end
endmodule